// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer with Demap

This block is a sixteen-entry, fully associative translation cache. Each entry pairs a tag with a 64-bit translation word. The tag holds the virtual page number, which is address bits 63:13 for a fixed 8 KB page, and a 10-bit context identifier. A lookup presents a virtual address and a context selector. One cycle later the block returns a registered hit flag and the translation word of the matching entry.

A single command port serves three purposes. It reads and writes the two context registers, primary and secondary. It accepts demap commands, which remove entries by page, by whole context, or all unlocked entries at once. It also gives indexed diagnostic access to the tag and the translation word of every entry.

A command carries a space code, an address and write data. Read results return on a registered read-data output one cycle after the read is issued. The read-data output keeps its value until the next read.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every entry is invalid, both context registers read zero, `lkHit` is low, and `lkData` and `rdData` are zero.
- R2: A lookup (`lkValid` high) hits when a valid entry's page number equals `lkVaddr[63:13]` and its context equals the selected context. The selector values are: 0 for the primary register, 1 for the secondary register, 2 for the nucleus context (value 0), and 3, which never hits. `lkHit` and `lkData` appear in the cycle after the request.
- R3: A lookup with no matching valid entry, or a cycle without a request, gives `lkHit` low and `lkData` zero one cycle later.
- R4: When several valid entries match, the translation word of the lowest-indexed entry is returned.
- R5: Context registers live in space 0, with the primary register at byte offset 0x08 and the secondary register at 0x10, decoded on address bits 12:0. A write keeps only the low 10 bits. A read returns the value zero-extended. A write to any other offset changes neither register.
- R6: Diagnostic accesses use space 2 for the translation word and space 3 for the tag, with the entry index taken from address bits 6:3. In the translation word, bit 63 is the valid bit and bit 6 is the lock bit. The tag word carries the page number in bits 63:13 and the context in bits 9:0.
- R7: A diagnostic read of a translation word returns it with bits 49:41 forced to zero. A tag read returns bits 12:10 as zero.
- R8: A write in space 1 is a demap. With address bit 7 and bit 6 clear, it invalidates every valid entry whose page number equals address bits 63:13 and whose context equals the one chosen by address bits 5:4. The codes for bits 5:4 are 0 primary, 1 secondary and 2 nucleus. Locked entries are removed too.
- R9: A demap with bit 7 clear and bit 6 set invalidates every valid entry of the chosen context, locked or not.
- R10: A demap with address bit 7 set invalidates every valid unlocked entry and leaves locked entries valid.
- R11: When a demap and a lookup occur in the same cycle, the lookup result reflects the array after the demap.
- R12: A page or context demap with bits 5:4 equal to 3 invalidates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request |
| lkVaddr | input | 64 | Lookup virtual address |
| lkCtxSel | input | 2 | Lookup context selector |
| lkHit | output | 1 | Registered hit flag |
| lkData | output | 64 | Registered translation word, zero on a miss |
| cmdValid | input | 1 | Command strobe |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdSpace | input | 2 | 0 context registers, 1 demap, 2 diagnostic translation word, 3 diagnostic tag |
| cmdAddr | input | 64 | Command address |
| cmdWdata | input | 64 | Command write data |
| rdData | output | 64 | Registered read result, held between reads |

## Verification
The two functions that can coincide are a demap on the command port and a lookup on the lookup port. The bench issues a context demap of the primary context in the same cycle as a lookup of a primary entry. It then issues a demap-all together with a lookup of an unlocked entry. In both cases it expects a miss. It also pairs a page demap of an unrelated page with a lookup that must still hit. A behavioural reference model applies the demap before it resolves the lookup, and every cycle the outputs are compared against that model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int TLB_ENTRIES = 16;
  parameter int VA_W        = 64;
  parameter int PAGE_BITS   = 13;
  parameter int CTX_W       = 10;
  parameter int DATA_W      = 64;
  parameter int VALID_POS   = 63;
  parameter int LOCK_POS    = 6;
  parameter int DIAG_LO     = 41;
  parameter int DIAG_HI     = 49;
  parameter int IDX_LSB     = 3;
  parameter int DM_ALL_BIT  = 7;
  parameter int DM_SCOPE_BIT = 6;
  parameter int DM_SEL_LO   = 4;
  parameter int PRIM_OFF    = 8;
  parameter int SEC_OFF     = 16;

  localparam int IDX_W   = $clog2(TLB_ENTRIES);
  localparam int VPN_W   = VA_W - PAGE_BITS;
  localparam int TAG_GAP = PAGE_BITS - CTX_W;

  typedef enum logic [1:0] {SP_MMUREG, SP_DEMAP, SP_DIAGDATA, SP_DIAGTAG} space_e;
  typedef enum logic [1:0] {RD_NONE, RD_CTX, RD_DATA, RD_TAG} rdSrc_e;

  typedef struct packed {
    logic              demapPage;
    logic              demapCtx;
    logic              demapAll;
    logic [VPN_W-1:0]  demapVpn;
    logic [CTX_W-1:0]  demapCtxVal;
    logic              diagDataWr;
    logic              diagTagWr;
    logic [IDX_W-1:0]  diagIdx;
    logic [DATA_W-1:0] wdata;
    rdSrc_e            rdSrc;
    logic [CTX_W-1:0]  rdCtx;
    logic              lkCtxOk;
    logic [CTX_W-1:0]  lkCtx;
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [1:0]        cmdSpace,
  input  logic [VA_W-1:0]   cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [1:0]        lkCtxSel,
  output tlbStrobe_t        strb
);
  logic [CTX_W-1:0] primCtx, secCtx;
  logic [CTX_W-1:0] dmCtx, lkCtxV;
  logic dmOk, lkOk;
  space_e space;
  logic isWr, isRd, primSel, secSel;

  assign space   = space_e'(cmdSpace);
  assign isWr    = cmdValid & cmdWrite;
  assign isRd    = cmdValid & ~cmdWrite;
  assign primSel = cmdAddr[PAGE_BITS-1:0] == PAGE_BITS'(PRIM_OFF);
  assign secSel  = cmdAddr[PAGE_BITS-1:0] == PAGE_BITS'(SEC_OFF);

  function automatic logic [CTX_W:0] pickCtx(input logic [1:0] sel,
                                             input logic [CTX_W-1:0] p,
                                             input logic [CTX_W-1:0] s);
    case (sel)
      2'd0:    return {1'b1, p};
      2'd1:    return {1'b1, s};
      2'd2:    return {1'b1, {CTX_W{1'b0}}};
      default: return {1'b0, {CTX_W{1'b0}}};
    endcase
  endfunction

  assign {dmOk, dmCtx}  = pickCtx(cmdAddr[DM_SEL_LO +: 2], primCtx, secCtx);
  assign {lkOk, lkCtxV} = pickCtx(lkCtxSel, primCtx, secCtx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primCtx <= '0;
      secCtx  <= '0;
    end else if (isWr && space == SP_MMUREG) begin
      if (primSel) primCtx <= cmdWdata[CTX_W-1:0];
      if (secSel)  secCtx  <= cmdWdata[CTX_W-1:0];
    end
  end

  always_comb begin
    strb             = '0;
    strb.lkCtxOk     = lkOk;
    strb.lkCtx       = lkCtxV;
    strb.demapVpn    = cmdAddr[VA_W-1:PAGE_BITS];
    strb.demapCtxVal = dmCtx;
    strb.diagIdx     = cmdAddr[IDX_LSB +: IDX_W];
    strb.wdata       = cmdWdata;
    strb.diagDataWr  = isWr && space == SP_DIAGDATA;
    strb.diagTagWr   = isWr && space == SP_DIAGTAG;
    if (isWr && space == SP_DEMAP) begin
      if (cmdAddr[DM_ALL_BIT])        strb.demapAll  = 1'b1;
      else if (dmOk) begin
        if (cmdAddr[DM_SCOPE_BIT])    strb.demapCtx  = 1'b1;
        else                          strb.demapPage = 1'b1;
      end
    end
    if (isRd) begin
      case (space)
        SP_MMUREG: begin
          if (primSel) begin
            strb.rdSrc = RD_CTX;
            strb.rdCtx = primCtx;
          end else if (secSel) begin
            strb.rdSrc = RD_CTX;
            strb.rdCtx = secCtx;
          end
        end
        SP_DIAGDATA: strb.rdSrc = RD_DATA;
        SP_DIAGTAG:  strb.rdSrc = RD_TAG;
        default:     strb.rdSrc = RD_NONE;
      endcase
    end
  end

  // R5: primary register keeps the low bits of the written value
  p_prim_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && space == SP_MMUREG && primSel) |=> primCtx == $past(cmdWdata[CTX_W-1:0]));
  // R5: secondary register likewise
  p_sec_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && space == SP_MMUREG && secSel) |=> secCtx == $past(cmdWdata[CTX_W-1:0]));
  // R5: registers hold without a register write
  p_ctx_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(isWr && space == SP_MMUREG) |=> ($stable(primCtx) && $stable(secCtx)));
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strb,
  input  logic              lkValid,
  input  logic [VPN_W-1:0]  lkVpn,
  output logic              lkHit,
  output logic [DATA_W-1:0] lkData,
  output logic [DATA_W-1:0] rdData
);
  function automatic logic [DATA_W-1:0] diagMask();
    logic [DATA_W-1:0] m;
    for (int b = 0; b < DATA_W; b++) m[b] = !(b >= DIAG_LO && b <= DIAG_HI);
    return m;
  endfunction
  localparam logic [DATA_W-1:0] DIAG_MASK = diagMask();

  logic [TLB_ENTRIES-1:0][DATA_W-1:0] dataArr;
  logic [TLB_ENTRIES-1:0][VPN_W-1:0]  vpnArr;
  logic [TLB_ENTRIES-1:0][CTX_W-1:0]  ctxArr;
  logic [TLB_ENTRIES-1:0] validVec, lockVec, killVec, hitVec;

  for (genvar e = 0; e < TLB_ENTRIES; e++) begin : g_ent
    logic [DATA_W-1:0] dataQ;
    logic [VPN_W-1:0]  vpnQ;
    logic [CTX_W-1:0]  ctxQ;
    logic selThis, dmCtxEq, dmVpnEq;

    assign selThis = strb.diagIdx == IDX_W'(e);
    assign dmCtxEq = ctxQ == strb.demapCtxVal;
    assign dmVpnEq = vpnQ == strb.demapVpn;
    assign killVec[e] = dataQ[VALID_POS] &
                        ((strb.demapAll & ~dataQ[LOCK_POS]) |
                         (strb.demapCtx & dmCtxEq) |
                         (strb.demapPage & dmCtxEq & dmVpnEq));
    assign hitVec[e] = dataQ[VALID_POS] & ~killVec[e] & strb.lkCtxOk &
                       (vpnQ == lkVpn) & (ctxQ == strb.lkCtx);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataQ <= '0;
        vpnQ  <= '0;
        ctxQ  <= '0;
      end else if (strb.diagDataWr && selThis) begin
        dataQ <= strb.wdata;
      end else if (strb.diagTagWr && selThis) begin
        vpnQ <= strb.wdata[DATA_W-1:PAGE_BITS];
        ctxQ <= strb.wdata[CTX_W-1:0];
      end else if (killVec[e]) begin
        dataQ[VALID_POS] <= 1'b0;
      end
    end

    assign dataArr[e]  = dataQ;
    assign vpnArr[e]   = vpnQ;
    assign ctxArr[e]   = ctxQ;
    assign validVec[e] = dataQ[VALID_POS];
    assign lockVec[e]  = dataQ[LOCK_POS];
  end

  logic [IDX_W-1:0] winIdx;
  logic anyHit;
  always_comb begin
    winIdx = '0;
    anyHit = |hitVec;
    for (int i = TLB_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) winIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lkHit  <= 1'b0;
      lkData <= '0;
    end else begin
      lkHit  <= lkValid & anyHit;
      lkData <= (lkValid & anyHit) ? dataArr[winIdx] : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else begin
      case (strb.rdSrc)
        RD_CTX:  rdData <= DATA_W'(strb.rdCtx);
        RD_DATA: rdData <= dataArr[strb.diagIdx] & DIAG_MASK;
        RD_TAG:  rdData <= {vpnArr[strb.diagIdx], {TAG_GAP{1'b0}}, ctxArr[strb.diagIdx]};
        default: rdData <= rdData;
      endcase
    end
  end

  // R3: a miss returns a zero word
  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> lkData == '0);
  // R2: a hit only follows a request
  p_hit_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> $past(lkValid));
  // R10: locked entries survive demap-all
  p_lock_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.demapAll |=> (validVec & $past(validVec & lockVec)) == $past(validVec & lockVec));
  // R10: no unlocked entry stays valid after demap-all
  p_unlock_gone_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.demapAll |=> (validVec & ~lockVec) == '0);
  // R7: diagnostic field reads back as zero
  p_diag_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSrc == RD_DATA) |=> rdData[DIAG_HI:DIAG_LO] == '0);
  // R11: a context demap hides that context from a same-cycle lookup
  p_demap_first_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.demapCtx && lkValid && strb.lkCtxOk && strb.lkCtx == strb.demapCtxVal) |=> !lkHit);
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [VA_W-1:0]   lkVaddr,
  input  logic [1:0]        lkCtxSel,
  output logic              lkHit,
  output logic [DATA_W-1:0] lkData,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [1:0]        cmdSpace,
  input  logic [VA_W-1:0]   cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  output logic [DATA_W-1:0] rdData
);
  tlbStrobe_t strb;
  logic unusedPageOffset;
  assign unusedPageOffset = ^lkVaddr[PAGE_BITS-1:0];

  tlb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdWrite (cmdWrite),
    .cmdSpace (cmdSpace),
    .cmdAddr  (cmdAddr),
    .cmdWdata (cmdWdata),
    .lkCtxSel (lkCtxSel),
    .strb     (strb)
  );

  tlb_array u_array (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .lkValid (lkValid),
    .lkVpn   (lkVaddr[VA_W-1:PAGE_BITS]),
    .lkHit   (lkHit),
    .lkData  (lkData),
    .rdData  (rdData)
  );
endmodule

// File: tb/ctx_tlb_tb.sv
module ctx_tlb_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkValid = 1'b0;
  logic [63:0] lkVaddr = '0;
  logic [1:0] lkCtxSel = '0;
  logic lkHit;
  logic [63:0] lkData;
  logic cmdValid = 1'b0;
  logic cmdWrite = 1'b0;
  logic [1:0] cmdSpace = '0;
  logic [63:0] cmdAddr = '0;
  logic [63:0] cmdWdata = '0;
  logic [63:0] rdData;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  ctx_tlb u_dut (.*);

  // behavioural reference state
  logic [63:0] mData [16];
  logic [50:0] mVpn [16];
  logic [9:0]  mCtx [16];
  logic [9:0]  mPrim, mSec;
  logic        mHit;
  logic [63:0] mLk, mRd;

  function automatic bit ctxFor(input logic [1:0] s, output logic [9:0] c);
    c = '0;
    if (s == 2'd0) begin c = mPrim; return 1; end
    if (s == 2'd1) begin c = mSec; return 1; end
    if (s == 2'd2) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin : model
    logic [9:0] c;
    bit ok;
    bit found;
    logic [63:0] d;
    int ix;
    if (!rstN) begin
      for (int i = 0; i < 16; i++) begin mData[i] = '0; mVpn[i] = '0; mCtx[i] = '0; end
      mPrim = '0; mSec = '0; mHit = 0; mLk = '0; mRd = '0;
    end else begin
      ix = int'(cmdAddr[6:3]);
      if (cmdValid && cmdWrite && cmdSpace == 2'd1) begin
        if (cmdAddr[7]) begin
          for (int i = 0; i < 16; i++) if (!mData[i][6]) mData[i][63] = 1'b0;
        end else begin
          ok = ctxFor(cmdAddr[5:4], c);
          if (ok)
            for (int i = 0; i < 16; i++)
              if (mData[i][63] && mCtx[i] == c && (cmdAddr[6] || mVpn[i] == cmdAddr[63:13]))
                mData[i][63] = 1'b0;
        end
      end
      found = 0; d = '0;
      ok = ctxFor(lkCtxSel, c);
      if (lkValid && ok)
        for (int i = 0; i < 16; i++)
          if (!found && mData[i][63] && mVpn[i] == lkVaddr[63:13] && mCtx[i] == c) begin
            found = 1; d = mData[i];
          end
      mHit = found; mLk = d;
      if (cmdValid && !cmdWrite) begin
        case (cmdSpace)
          2'd0: if (cmdAddr[12:0] == 13'h8) mRd = {54'd0, mPrim};
                else if (cmdAddr[12:0] == 13'h10) mRd = {54'd0, mSec};
          2'd2: mRd = mData[ix] & ~(64'h1FF << 41);
          2'd3: mRd = {mVpn[ix], 3'b000, mCtx[ix]};
          default: ;
        endcase
      end
      if (cmdValid && cmdWrite) begin
        case (cmdSpace)
          2'd0: if (cmdAddr[12:0] == 13'h8) mPrim = cmdWdata[9:0];
                else if (cmdAddr[12:0] == 13'h10) mSec = cmdWdata[9:0];
          2'd2: mData[ix] = cmdWdata;
          2'd3: begin mVpn[ix] = cmdWdata[63:13]; mCtx[ix] = cmdWdata[9:0]; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  task automatic idle();
    lkValid = 0; lkVaddr = '0; lkCtxSel = '0;
    cmdValid = 0; cmdWrite = 0; cmdSpace = '0; cmdAddr = '0; cmdWdata = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(lkHit === mHit, "lkHit", {63'd0, lkHit}, {63'd0, mHit});
    chk(lkData === mLk, "lkData", lkData, mLk);
    chk(rdData === mRd, "rdData", rdData, mRd);
    idle();
  endtask

  task automatic setLook(input logic [50:0] vpn, input logic [1:0] sel);
    lkValid = 1; lkVaddr = {vpn, 13'h0A4}; lkCtxSel = sel;
  endtask

  task automatic setCmd(input bit wr, input logic [1:0] sp, input logic [63:0] a, input logic [63:0] wd);
    cmdValid = 1; cmdWrite = wr; cmdSpace = sp; cmdAddr = a; cmdWdata = wd;
  endtask

  task automatic look(input logic [50:0] vpn, input logic [1:0] sel);
    setLook(vpn, sel); step();
  endtask

  task automatic doCmd(input bit wr, input logic [1:0] sp, input logic [63:0] a, input logic [63:0] wd);
    setCmd(wr, sp, a, wd); step();
  endtask

  task automatic loadEnt(input int idx, input logic [50:0] vpn, input logic [9:0] ctx, input logic [63:0] d);
    doCmd(1, 2'd3, 64'(idx) << 3, {vpn, 3'b111, ctx});
    doCmd(1, 2'd2, 64'(idx) << 3, d);
  endtask

  localparam logic [63:0] V = 64'h8000_0000_0000_0000;
  localparam logic [63:0] L = 64'h40;
  localparam logic [50:0] PA = 51'h12345, PB = 51'h2_0000_0007, PC = 51'h777,
                          PD = 51'h5_5555_0000, PE = 51'h99, PF = 51'h4_0000_0001,
                          PG = 51'h3, PH = 51'hABCD, PI = 51'hABCE, PJ = 51'hABCF;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    curReq = "R1";
    step();
    look(51'h0, 2'd2);
    doCmd(0, 2'd0, 64'h8, '0);
    doCmd(0, 2'd0, 64'h10, '0);
    // R5: context register writes and reads
    curReq = "R5";
    doCmd(1, 2'd0, 64'h8, 64'hFFFF_FFFF_0000_77F5);
    doCmd(1, 2'd0, 64'h10, 64'h12345);
    doCmd(1, 2'd0, 64'h18, 64'h3FF);
    doCmd(0, 2'd0, 64'h8, '0);
    doCmd(0, 2'd0, 64'h10, '0);
    // R6: diagnostic loading and tag readback
    curReq = "R6";
    loadEnt(0, PA, 10'h3F5, V | 64'h1000);
    loadEnt(1, PA, 10'h3F5, V | 64'h2000);
    loadEnt(2, PB, 10'h345, V | 64'h3000);
    loadEnt(3, PC, 10'h000, V | L | 64'h4000);
    loadEnt(4, PD, 10'h3F5, V | L | 64'h5000);
    loadEnt(5, PE, 10'h3F5, V | 64'h6000);
    loadEnt(6, PF, 10'h345, V | L | 64'h0003_FE00_00AB_C000);
    loadEnt(7, PG, 10'h000, 64'h7000);
    doCmd(0, 2'd2, 64'h10, '0);
    // R7: diagnostic field cleared on read, tag gap zero
    curReq = "R7";
    doCmd(0, 2'd2, 64'h30, '0);
    doCmd(0, 2'd3, 64'h10, '0);
    // R2: hits through each selector
    curReq = "R2";
    look(PA, 2'd0);
    look(PB, 2'd1);
    look(PC, 2'd2);
    look(PA, 2'd3);
    step();
    // R3: misses
    curReq = "R3";
    look(PB, 2'd0);
    look(PG, 2'd2);
    look(51'h0, 2'd0);
    // R4: lowest index wins, then next after invalidation
    curReq = "R4";
    look(PA, 2'd0);
    doCmd(1, 2'd2, 64'h0, 64'h1000);
    look(PA, 2'd0);
    // R8: page demap, lock does not protect
    curReq = "R8";
    doCmd(1, 2'd1, {PB, 13'h0010}, '0);
    look(PB, 2'd1);
    doCmd(1, 2'd1, {PD, 13'h0000}, '0);
    look(PD, 2'd0);
    look(PE, 2'd0);
    // R12: reserved selector has no effect
    curReq = "R12";
    doCmd(1, 2'd1, 64'h70, '0);
    doCmd(1, 2'd1, {PE, 13'h0030}, '0);
    look(PE, 2'd0);
    // R11: demap and lookup in one cycle
    curReq = "R11";
    setCmd(1, 2'd1, {PG, 13'h0020}, '0); setLook(PC, 2'd2); step();
    setCmd(1, 2'd1, 64'h40, '0); setLook(PE, 2'd0); step();
    look(PA, 2'd0);
    // R9: whole-context demap removes a locked nucleus entry
    curReq = "R9";
    doCmd(1, 2'd1, 64'h60, '0);
    look(PC, 2'd2);
    look(PF, 2'd1);
    // R10: demap-all spares locked entries
    curReq = "R10";
    loadEnt(8, PH, 10'h3F5, V | L | 64'h8000);
    loadEnt(9, PI, 10'h3F5, V | 64'h9000);
    loadEnt(10, PJ, 10'h345, V | L | 64'hA000);
    setCmd(1, 2'd1, 64'h80, '0); setLook(PI, 2'd0); step();
    look(PH, 2'd0);
    look(PJ, 2'd1);
    look(PF, 2'd1);
    doCmd(0, 2'd2, 64'h48, '0);
    doCmd(0, 2'd2, 64'h40, '0);
    step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule